// File: doc/BRIEF.md
# Posted-Write Address Window Router

This block sits on the write path between an AXI write slave and a downstream link that carries write requests. Every incoming single-beat write has its 40-bit address compared against two programmable windows, each defined over address bits [39:24]. A write that lands in an enabled window goes downstream marked as posted, and its write response is produced straight away, without waiting for the link. A write that lands in no enabled window goes downstream marked as non-posted. Its response stays back until the link returns a completion, and it carries the completion's status.

A window that hits also rewrites the upper address bits. Every bit under the window's mask takes its value from the window's translation field, and every other bit comes from the incoming address. A small register file, with two 32-bit registers per window, holds the enable, a stored-only unpack flag, the translation, the base and the mask. The router handles one write at a time. While a request is pending at the link, a completion is awaited or a response has not been taken, it holds off new writes.

Top module: `pwin_router`

## Requirements
- R1: After reset every window register reads zero, both windows are disabled, `s_awready` is 1 and `s_bvalid` is 0. A write issued before any programming therefore goes out non-posted.
- R2: Window i hits only when its enable bit is 1 and `(addr[39:24] & mask) == (base & mask)`. A disabled window never hits.
- R3: A write that hits is accepted when `s_awvalid`, `s_wvalid` and `s_awready` are all 1 on a clock edge. From the next cycle, `m_req_valid` is 1 with `m_req_posted`=1, and `s_bvalid` is 1 with `s_bid` equal to the accepted AWID and `s_bresp`=2'b00, independent of `m_req_ready`. `m_req_addr`, `m_req_data` and `m_req_strb` stay stable until `m_req_ready` is seen.
- R4: A write that misses every enabled window goes out with `m_req_posted`=0 and its address unchanged. `s_bvalid` rises only in the cycle after `m_cpl_valid` is seen, once the request has been taken. `s_bresp` then equals `m_cpl_status` and `s_bid` equals the AWID of that write.
- R5: On a hit, `m_req_addr[39:24]` = `(trans & mask) | (addr[39:24] & ~mask)`, and bits [23:0] pass through unchanged.
- R6: When both windows hit, window 0's translation is used.
- R7: `s_awready` (and `s_wready`) is 1 only when no request is pending downstream, no completion is awaited and no write response is waiting to be taken. `m_cpl_valid` is ignored when no completion is awaited.
- R8: Register map, by byte offset on `cfg_addr`. Offset 0x0 (window 0) and 0x8 (window 1) hold the control register: enable in bit 31, unpack flag in bit 30, translation in bits 15:0. Offset 0x4 (window 0) and 0xC (window 1) hold base in bits 31:16 and mask in bits 15:0. Writes take effect on the next edge, and `cfg_rdata` shows the register at `cfg_addr` combinationally.
- R9: Control register bits 29:16 read as zero and ignore written values.
- R10: The unpack flag is stored and read back, but it has no effect on hit, translation or response timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awid | input | 4 | Write transaction ID |
| s_awaddr | input | 40 | Write address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready (same as `s_awready`) |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bid | output | 4 | Write response ID |
| s_bresp | output | 2 | Write response status |
| m_req_valid | output | 1 | Downstream request valid |
| m_req_ready | input | 1 | Downstream request ready |
| m_req_addr | output | 40 | Translated request address |
| m_req_data | output | 32 | Request data |
| m_req_strb | output | 4 | Request byte strobes |
| m_req_posted | output | 1 | 1 = posted write, 0 = non-posted |
| m_cpl_valid | input | 1 | Downstream completion for the non-posted write |
| m_cpl_status | input | 2 | Completion status |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |

## Verification
The hardest state to reach is two windows that overlap while a write is in flight. Both windows must hit one address, and the address must be held stable while the router is still stalled on a posted response that has not been taken, or on a completion that has not arrived. The stimulus programs window 1 to cover a narrow region inside window 0. It draws addresses from that overlap, from each window alone and from outside both. Back-pressure on `m_req_ready`, `s_bready` and `m_cpl_valid` is random, so every stall source arises with each routing kind. The windows are later disabled and rewritten with all-ones data, which covers the disabled-window and reserved-bit rules while traffic keeps flowing.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } rt_state_t;

  localparam int CTRL_EN_BIT  = 31;
  localparam int CTRL_UNP_BIT = 30;
  localparam int BM_BASE_LO   = 16;
  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/pwin_regs.sv
module pwin_regs import pwin_pkg::*; #(
  parameter int NWIN = 2,
  parameter int WF   = 16,
  parameter int CA_W = $clog2(NWIN) + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CA_W-1:0]          cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  output logic [NWIN-1:0]          win_en,
  output logic [NWIN-1:0][WF-1:0]  win_base,
  output logic [NWIN-1:0][WF-1:0]  win_mask,
  output logic [NWIN-1:0][WF-1:0]  win_trans
);
  localparam int IDX_W = CA_W - 3;

  logic [NWIN-1:0]     win_unp;
  logic [IDX_W-1:0]    sel_idx;
  logic                sel_bm;

  assign sel_idx = cfg_addr[CA_W-1:3];
  assign sel_bm  = cfg_addr[2];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic hit_ctrl, hit_bm;
    assign hit_ctrl = cfg_we && (sel_idx == IDX_W'(i)) && !sel_bm;
    assign hit_bm   = cfg_we && (sel_idx == IDX_W'(i)) &&  sel_bm;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_en[i]    <= 1'b0;
        win_unp[i]   <= 1'b0;
        win_trans[i] <= '0;
        win_base[i]  <= '0;
        win_mask[i]  <= '0;
      end else begin
        if (hit_ctrl) begin
          win_en[i]    <= cfg_wdata[CTRL_EN_BIT];
          win_unp[i]   <= cfg_wdata[CTRL_UNP_BIT];
          win_trans[i] <= cfg_wdata[WF-1:0];
        end
        if (hit_bm) begin
          win_base[i] <= cfg_wdata[BM_BASE_LO +: WF];
          win_mask[i] <= cfg_wdata[WF-1:0];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (sel_idx == IDX_W'(i)) begin
        if (sel_bm) begin
          cfg_rdata[BM_BASE_LO +: WF] = win_base[i];
          cfg_rdata[WF-1:0]           = win_mask[i];
        end else begin
          cfg_rdata[CTRL_EN_BIT]  = win_en[i];
          cfg_rdata[CTRL_UNP_BIT] = win_unp[i];
          cfg_rdata[WF-1:0]       = win_trans[i];
        end
      end
    end
  end

  assert_resv_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_bm |-> (cfg_rdata[29:16] == 14'd0));
endmodule

// File: rtl/pwin_match.sv
module pwin_match #(
  parameter int NWIN = 2,
  parameter int WF   = 16
) (
  input  logic [WF-1:0]            addr_hi,
  input  logic [NWIN-1:0]          win_en,
  input  logic [NWIN-1:0][WF-1:0]  win_base,
  input  logic [NWIN-1:0][WF-1:0]  win_mask,
  input  logic [NWIN-1:0][WF-1:0]  win_trans,
  output logic [NWIN-1:0]          win_hit,
  output logic [NWIN-1:0]          win_sel,
  output logic                     any_hit,
  output logic [WF-1:0]            xl_hi
);
  function automatic logic f_hit(input logic en, input logic [WF-1:0] a,
                                 input logic [WF-1:0] base, input logic [WF-1:0] mask);
    return en && ((a & mask) == (base & mask));
  endfunction

  function automatic logic [WF-1:0] f_xlate(input logic [WF-1:0] a,
                                            input logic [WF-1:0] trans, input logic [WF-1:0] mask);
    return (trans & mask) | (a & ~mask);
  endfunction

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    assign win_hit[i] = f_hit(win_en[i], addr_hi, win_base[i], win_mask[i]);
  end

  always_comb begin
    win_sel = '0;
    xl_hi   = addr_hi;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        win_sel = '0;
        win_sel[i] = 1'b1;
        xl_hi = f_xlate(addr_hi, win_trans[i], win_mask[i]);
      end
    end
  end

  assign any_hit = |win_hit;
endmodule

// File: rtl/pwin_ctrl.sv
module pwin_ctrl import pwin_pkg::*; #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              w_valid,
  input  logic [DATA_W-1:0] w_data,
  input  logic [STRB_W-1:0] w_strb,
  input  logic [ADDR_W-1:0] routed_addr,
  input  logic              is_posted,
  output logic              aw_ready,
  output logic              accept,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [STRB_W-1:0] req_strb,
  output logic              req_posted,
  input  logic              cpl_valid,
  input  logic [1:0]        cpl_status
);
  rt_state_t       st;
  logic [ID_W-1:0] cur_id;

  assign aw_ready  = (st == ST_IDLE) && !b_valid;
  assign accept    = aw_valid && w_valid && aw_ready;
  assign req_valid = (st == ST_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_id     <= '0;
      b_valid    <= 1'b0;
      b_id       <= '0;
      b_resp     <= RESP_OKAY;
      req_addr   <= '0;
      req_data   <= '0;
      req_strb   <= '0;
      req_posted <= 1'b0;
    end else begin
      if (b_valid && b_ready) b_valid <= 1'b0;
      if (accept) begin
        st         <= ST_REQ;
        cur_id     <= aw_id;
        req_addr   <= routed_addr;
        req_data   <= w_data;
        req_strb   <= w_strb;
        req_posted <= is_posted;
        if (is_posted) begin
          b_valid <= 1'b1;
          b_id    <= aw_id;
          b_resp  <= RESP_OKAY;
        end
      end else begin
        case (st)
          ST_REQ:  if (req_ready) st <= req_posted ? ST_IDLE : ST_WAIT;
          ST_WAIT: if (cpl_valid) begin
            b_valid <= 1'b1;
            b_id    <= cur_id;
            b_resp  <= cpl_status;
            st      <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    aw_ready |-> (!req_valid && !b_valid));
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)));
  assert_posted_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_posted) |=> (b_valid && b_resp == RESP_OKAY && req_posted));
  assert_np_no_early_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_posted) |=> (!b_valid && !req_posted));
endmodule

// File: rtl/pwin_router.sv
module pwin_router #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int NWIN   = 2,
  parameter int WIN_LO = 24,
  parameter int WF     = ADDR_W - WIN_LO,
  parameter int STRB_W = DATA_W / 8,
  parameter int CA_W   = $clog2(NWIN) + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic [ADDR_W-1:0] m_req_addr,
  output logic [DATA_W-1:0] m_req_data,
  output logic [STRB_W-1:0] m_req_strb,
  output logic              m_req_posted,
  input  logic              m_cpl_valid,
  input  logic [1:0]        m_cpl_status,
  input  logic              cfg_we,
  input  logic [CA_W-1:0]   cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);
  logic [NWIN-1:0]          win_en, win_hit, win_sel;
  logic [NWIN-1:0][WF-1:0]  win_base, win_mask, win_trans;
  logic                     any_hit, accept;
  logic [WF-1:0]            xl_hi;
  logic [ADDR_W-1:0]        routed_addr;

  pwin_regs #(.NWIN(NWIN), .WF(WF), .CA_W(CA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win_en(win_en),
    .win_base(win_base), .win_mask(win_mask), .win_trans(win_trans)
  );

  pwin_match #(.NWIN(NWIN), .WF(WF)) u_match (
    .addr_hi(s_awaddr[ADDR_W-1:WIN_LO]), .win_en(win_en), .win_base(win_base),
    .win_mask(win_mask), .win_trans(win_trans), .win_hit(win_hit),
    .win_sel(win_sel), .any_hit(any_hit), .xl_hi(xl_hi)
  );

  assign routed_addr = {xl_hi, s_awaddr[WIN_LO-1:0]};
  assign s_wready    = s_awready;

  pwin_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .STRB_W(STRB_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .aw_valid(s_awvalid), .aw_id(s_awid),
    .w_valid(s_wvalid), .w_data(s_wdata), .w_strb(s_wstrb),
    .routed_addr(routed_addr), .is_posted(any_hit), .aw_ready(s_awready),
    .accept(accept), .b_valid(s_bvalid), .b_ready(s_bready), .b_id(s_bid),
    .b_resp(s_bresp), .req_valid(m_req_valid), .req_ready(m_req_ready),
    .req_addr(m_req_addr), .req_data(m_req_data), .req_strb(m_req_strb),
    .req_posted(m_req_posted), .cpl_valid(m_cpl_valid), .cpl_status(m_cpl_status)
  );

  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel) && (any_hit == (win_sel != '0)));
  assert_win0_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit[0] |-> win_sel[0]);
  assert_disabled_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en == '0) |-> !any_hit);
endmodule

// File: tb/test_pwin_router.sv
module test_pwin_router;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 6000;
  localparam int WDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b0;
  logic [3:0]  s_awid = '0;
  logic [39:0] s_awaddr = '0;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        m_req_ready = 1'b0, m_cpl_valid = 1'b0;
  logic [1:0]  m_cpl_status = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        s_awready, s_wready, s_bvalid, m_req_valid, m_req_posted;
  logic [3:0]  s_bid, m_req_strb;
  logic [1:0]  s_bresp;
  logic [39:0] m_req_addr;
  logic [31:0] m_req_data, cfg_rdata;

  pwin_router i_pwin_router (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0, n_post = 0, n_np = 0, n_both = 0;

  // reference model state
  logic [31:0] r_ctrl [2];
  logic [31:0] r_bm   [2];
  int          m_phase = 0;     // 0 free, 1 request pending, 2 awaiting completion
  logic        m_bv = 0;
  logic [3:0]  m_bid = 0, m_cur = 0;
  logic [1:0]  m_bresp = 0;
  logic [39:0] m_addr = 0;
  logic [31:0] m_data = 0;
  logic [3:0]  m_strb = 0;
  logic        m_post = 0, m_acc = 0;
  string       m_rtag = "R4";

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic bit win_hits(int w, logic [15:0] a);
    bit h = r_ctrl[w][31];
    for (int b = 0; b < 16; b++)
      if (r_bm[w][b] && (a[b] != r_bm[w][16+b])) h = 0;
    return h;
  endfunction

  function automatic logic [15:0] win_map(int w, logic [15:0] a);
    logic [15:0] o;
    for (int b = 0; b < 16; b++) o[b] = r_bm[w][b] ? r_ctrl[w][b] : a[b];
    return o;
  endfunction

  always @(posedge clk) begin
    bit acc, h0, h1;
    cyc++;
    acc = rst_n && s_awvalid && s_wvalid && (m_phase == 0) && !m_bv;
    m_acc = acc;
    if (!rst_n) begin
      for (int w = 0; w < 2; w++) begin r_ctrl[w] = 0; r_bm[w] = 0; end
      m_phase = 0; m_bv = 0; m_bid = 0; m_bresp = 0;
    end else begin
      if (m_bv && s_bready) m_bv = 0;
      if (acc) begin
        h0 = win_hits(0, s_awaddr[39:24]);
        h1 = win_hits(1, s_awaddr[39:24]);
        m_post = h0 || h1;
        m_addr = s_awaddr;
        if (h0) m_addr[39:24] = win_map(0, s_awaddr[39:24]);
        else if (h1) m_addr[39:24] = win_map(1, s_awaddr[39:24]);
        m_data = s_wdata; m_strb = s_wstrb; m_cur = s_awid;
        m_rtag = (h0 && h1) ? "R6" : ((r_ctrl[0][30] || r_ctrl[1][30]) ? "R10" :
                 (m_post ? "R5" : (r_ctrl[0][31] || r_ctrl[1][31]) ? "R2" : "R1"));
        if (h0 && h1) n_both++;
        if (m_post) begin n_post++; m_bv = 1; m_bid = s_awid; m_bresp = 2'b00; end
        else n_np++;
        m_phase = 1;
      end else if (m_phase == 1) begin
        if (m_req_ready) m_phase = m_post ? 0 : 2;
      end else if (m_phase == 2) begin
        if (m_cpl_valid) begin m_bv = 1; m_bid = m_cur; m_bresp = m_cpl_status; m_phase = 0; end
      end
      if (cfg_we) begin
        if (cfg_addr[2]) r_bm[cfg_addr[3]] = cfg_wdata;
        else r_ctrl[cfg_addr[3]] = cfg_wdata & 32'hC000_FFFF;
      end
    end
  end

  task automatic new_write();
    int k = $urandom % 4;
    logic [15:0] hi;
    case (k)
      0: hi = {8'h12, 8'($urandom)};            // window 0 only region (mostly)
      1: hi = {12'h123, 4'($urandom)};          // overlap of both windows
      2: hi = 16'h5A00 ^ 16'($urandom % 3);     // other region
      default: hi = 16'($urandom);
    endcase
    s_awaddr  = {hi, 24'($urandom)};
    s_awid    = 4'($urandom);
    s_wdata   = $urandom;
    s_wstrb   = 4'($urandom);
    s_awvalid = ($urandom % 4) != 0;
    s_wvalid  = s_awvalid ? (($urandom % 5) != 0) : 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      // compare against the model
      chk("R7", "s_awready", 64'(s_awready), 64'((m_phase == 0) && !m_bv));
      chk("R7", "s_wready", 64'(s_wready), 64'((m_phase == 0) && !m_bv));
      chk("R3", "m_req_valid", 64'(m_req_valid), 64'(m_phase == 1));
      if (m_phase == 1) begin
        chk(m_rtag, "m_req_posted", 64'(m_req_posted), 64'(m_post));
        chk(m_post ? m_rtag : "R4", "m_req_addr", 64'(m_req_addr), 64'(m_addr));
        chk("R3", "m_req_data", {28'(0), m_req_strb, m_req_data}, {28'(0), m_strb, m_data});
      end
      chk("R4", "s_bvalid", 64'(s_bvalid), 64'(m_bv));
      if (m_bv) begin
        chk("R3", "s_bid", 64'(s_bid), 64'(m_bid));
        chk("R4", "s_bresp", 64'(s_bresp), 64'(m_bresp));
      end
      chk(cyc < 300 ? "R1" : (cfg_addr[2] ? "R8" : "R9"), "cfg_rdata", 64'(cfg_rdata),
          64'(cfg_addr[2] ? r_bm[cfg_addr[3]] : r_ctrl[cfg_addr[3]]));
      // drive next inputs
      if (!s_awvalid || !s_wvalid || m_acc) new_write();
      s_bready     = ($urandom % 3) != 0;
      m_req_ready  = ($urandom % 3) != 0;
      m_cpl_valid  = ($urandom % 4) == 0;
      m_cpl_status = 2'($urandom);
      cfg_we = 1'b0;
      cfg_addr = {2'($urandom), 2'b00};
      case (cyc)
        300:  begin cfg_we = 1; cfg_addr = 4'h4; cfg_wdata = 32'h1200_FF00; end
        301:  begin cfg_we = 1; cfg_addr = 4'h0; cfg_wdata = 32'h8000_00AB; end
        302:  begin cfg_we = 1; cfg_addr = 4'hC; cfg_wdata = 32'h1230_FFF0; end
        303:  begin cfg_we = 1; cfg_addr = 4'h8; cfg_wdata = 32'h8000_0055; end
        2500: begin cfg_we = 1; cfg_addr = 4'h8; cfg_wdata = 32'hC000_0055; end
        3500: begin cfg_we = 1; cfg_addr = 4'h0; cfg_wdata = 32'h7FFF_FFFF; end
        3501: begin cfg_we = 1; cfg_addr = 4'h4; cfg_wdata = 32'h12FF_F0F0; end
        4500: begin cfg_we = 1; cfg_addr = 4'h8; cfg_wdata = 32'hFFFF_FFFF; end
        4501: begin cfg_we = 1; cfg_addr = 4'hC; cfg_wdata = 32'h0000_0000; end
        default: ;
      endcase
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, checked through the ports (R1)
    chk("R1", "s_awready in reset", 64'(s_awready), 64'(1));
    chk("R1", "s_bvalid in reset", 64'(s_bvalid), 64'(0));
    chk("R1", "cfg_rdata in reset", 64'(cfg_rdata), 64'(0));
    rst_n = 1'b1;
    while (cyc < RUN_CYCLES && cyc < WDOG_CYCLES) @(negedge clk);
    chk("R3", "posted writes seen", 64'(n_post > 20), 64'(1));
    chk("R4", "non-posted writes seen", 64'(n_np > 20), 64'(1));
    chk("R6", "overlap writes seen", 64'(n_both > 5), 64'(1));
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WDOG_CYCLES);
    n_bad++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule